// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous host and an external 8K x 8 asynchronous static RAM. The host raises `req` with an address, a direction bit and (for stores) a data byte. It keeps them steady until `ready` pulses for one clock. The sequencer turns each request into the strobe pattern the RAM expects:
- two chip enables of opposite polarity,
- an active-low output enable,
- an active-low write strobe,
- a data byte whose driver is separate from its enable, so the pad can be tristated.

Every timing interval the RAM imposes is a parameter counted in whole clock cycles:
- `T_READ` is the address-to-data access time.
- `T_WP` is the write pulse width.
- `T_DW` is the data set-up before the write strobe rises.
- `T_OHZ` is the time the RAM keeps driving the bus after its output enable is removed.

The sequencer serves one request at a time, in arrival order. After every read it inserts a quiet gap before it next drives the bus. The shared data lines therefore never have two drivers.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, `ce1_n`, `oe_n` and `we_n` are 1, `ce2` is 0, `dq_oe` is 0, `ready` is 0 and `rdata` is 0.
- R2: Whenever no access is in progress, including the cycle in which `ready` is high, the RAM is deselected (`ce1_n`=1, `ce2`=0), `oe_n`=1, `we_n`=1 and `dq_oe`=0. The cycle after a request is accepted in idle, both enables are active.
- R3: `sram_addr` carries the requested address from the same clock edge that activates the enables. It stays unchanged for as long as the RAM is selected.
- R4: A read holds `we_n`=1 and `oe_n`=0 for `T_READ`+1 cycles and samples `dq_in` at the end of the last of them. `ready` goes high `T_READ`+2 clock edges after a request is presented to an idle sequencer, with `rdata` equal to the stored byte. `rdata` keeps that value until the next read completes.
- R5: A write lowers `we_n` for S = max(`T_WP`, `T_DW`-1) cycles. The write byte is driven from one cycle before `we_n` falls, so it is valid for at least `T_DW` cycles before `we_n` rises. `ready` goes high S+3 clock edges after a request is presented to an idle sequencer, one cycle after `we_n` returns high.
- R6: `dq_oe` is 1 only in the cycle just before `we_n` falls and while `we_n` is 0. It is never 1 while `oe_n` is 0.
- R7: After `oe_n` rises, `dq_oe` stays 0 for more than `T_OHZ` cycles. A RAM that keeps driving for `T_OHZ` cycles after `oe_n` rises is never driven against.
- R8: `ready` is high for exactly one cycle per request. A request presented in the cycle after a read's `ready` is held off for `T_OHZ` extra cycles.
- R9: `oe_n` and `we_n` are never both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Host request, held until `ready` |
| wr | input | 1 | 1 = store, 0 = load |
| addr | input | AW (13) | Host word address |
| wdata | input | DW (8) | Byte to store |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | DW (8) | Byte returned by the last load |
| sram_addr | output | AW (13) | RAM address lines |
| ce1_n | output | 1 | RAM enable, active low |
| ce2 | output | 1 | RAM enable, active high |
| oe_n | output | 1 | RAM output enable, active low |
| we_n | output | 1 | RAM write strobe, active low |
| dq_out | output | DW (8) | Byte driven toward the RAM |
| dq_oe | output | 1 | Driver enable for `dq_out` onto the data lines |
| dq_in | input | DW (8) | Byte seen on the data lines |

## Verification
The bench builds the sequencer with a 10-bit address (1024 words) and timing values `T_READ`=3, `T_WP`=2, `T_DW`=4 and `T_OHZ`=2. This narrows the space enough to store and read back every word twice, with two different patterns. Because `T_DW`-1 exceeds `T_WP`, the data set-up rather than the pulse width sets the strobe length. Because `T_OHZ` is 2, a turnaround that was one or two cycles short would collide with the RAM model's late release. The model produces wrong data until the access time has passed, so an early capture shows up as a data mismatch. Stores directly after loads are interleaved, which exercises the held-off latency after every read.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_RD_ACCESS  = 3'd1,
    ST_RD_CAPTURE = 3'd2,
    ST_WR_SETUP   = 3'd3,
    ST_WR_PULSE   = 3'd4,
    ST_WR_RECOVER = 3'd5,
    ST_TURNAROUND = 3'd6
  } seq_state_e;

  typedef struct packed {
    logic sel;     // both chip enables active
    logic oe_act;  // output enable asserted
    logic we_act;  // write strobe asserted
    logic drive;   // own data driver on
  } pin_ctl_t;

  // Cycles the write strobe stays low: long enough for the pulse width and,
  // with the one lead cycle of data, for the data set-up.
  function automatic int unsigned strobe_cycles(input int unsigned t_wp,
                                                input int unsigned t_dw);
    int unsigned lead_need;
    lead_need = (t_dw > 1) ? t_dw - 1 : 1;
    return (t_wp > lead_need) ? t_wp : lead_need;
  endfunction

  function automatic int unsigned cnt_bits(input int unsigned maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic pin_ctl_t decode_pins(input seq_state_e s);
    pin_ctl_t p;
    p = '0;
    unique case (s)
      ST_RD_ACCESS, ST_RD_CAPTURE: begin p.sel = 1'b1; p.oe_act = 1'b1; end
      ST_WR_SETUP:                 begin p.sel = 1'b1; p.drive = 1'b1; end
      ST_WR_PULSE:                 begin p.sel = 1'b1; p.we_act = 1'b1; p.drive = 1'b1; end
      ST_WR_RECOVER:               p.sel = 1'b1;
      default:                     p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned T_READ = 2,
  parameter int unsigned T_WP   = 2,
  parameter int unsigned T_DW   = 2,
  parameter int unsigned T_OHZ  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic wr,
  output logic accept_ev,
  output logic rd_capture_ev,
  output logic wr_done_ev,
  output logic ce1_n,
  output logic ce2,
  output logic oe_n,
  output logic we_n,
  output logic drive
);
  localparam int unsigned STB  = strobe_cycles(T_WP, T_DW);
  localparam int unsigned TMAX = max3(T_READ, STB, T_OHZ);
  localparam int unsigned CW   = cnt_bits(TMAX);
  localparam logic [CW-1:0] RD_LOAD  = CW'(T_READ - 1);
  localparam logic [CW-1:0] STB_LOAD = CW'(STB - 1);
  localparam logic [CW-1:0] OHZ_LOAD = CW'(T_OHZ - 1);

  seq_state_e state_q, state_d;
  logic          tmr_load, tmr_expired;
  logic [CW-1:0] tmr_val;
  pin_ctl_t      pins_d;
  logic          ce1_n_q, ce2_q, oe_n_q, we_n_q, drive_q;

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (req) begin
        if (wr) state_d = ST_WR_SETUP;
        else begin
          state_d  = ST_RD_ACCESS;
          tmr_load = 1'b1;
          tmr_val  = RD_LOAD;
        end
      end
      ST_RD_ACCESS:  if (tmr_expired) state_d = ST_RD_CAPTURE;
      ST_RD_CAPTURE: begin
        state_d  = ST_TURNAROUND;
        tmr_load = 1'b1;
        tmr_val  = OHZ_LOAD;
      end
      ST_TURNAROUND: if (tmr_expired) state_d = ST_IDLE;
      ST_WR_SETUP: begin
        state_d  = ST_WR_PULSE;
        tmr_load = 1'b1;
        tmr_val  = STB_LOAD;
      end
      ST_WR_PULSE:   if (tmr_expired) state_d = ST_WR_RECOVER;
      ST_WR_RECOVER: state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  assign pins_d = decode_pins(state_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ce1_n_q <= 1'b1;
      ce2_q   <= 1'b0;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      drive_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ce1_n_q <= ~pins_d.sel;
      ce2_q   <= pins_d.sel;
      oe_n_q  <= ~pins_d.oe_act;
      we_n_q  <= ~pins_d.we_act;
      drive_q <= pins_d.drive;
    end
  end

  assign accept_ev     = (state_q == ST_IDLE) && req;
  assign rd_capture_ev = (state_q == ST_RD_CAPTURE);
  assign wr_done_ev    = (state_q == ST_WR_RECOVER);
  assign ce1_n = ce1_n_q;
  assign ce2   = ce2_q;
  assign oe_n  = oe_n_q;
  assign we_n  = we_n_q;
  assign drive = drive_q;
endmodule

// File: rtl/sram_bus_regs.sv
module sram_bus_regs #(
  parameter int unsigned AW = 13,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          capture,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] dq_out,
  output logic [DW-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_addr <= '0;
      dq_out    <= '0;
    end else if (load) begin
      sram_addr <= host_addr;
      dq_out    <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (capture) rdata <= dq_in;
  end
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl #(
  parameter int unsigned AW     = 13,
  parameter int unsigned DW     = 8,
  parameter int unsigned T_READ = 2,
  parameter int unsigned T_WP   = 2,
  parameter int unsigned T_DW   = 2,
  parameter int unsigned T_OHZ  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] sram_addr,
  output logic          ce1_n,
  output logic          ce2,
  output logic          oe_n,
  output logic          we_n,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  input  logic [DW-1:0] dq_in
);
  logic accept_ev, rd_capture_ev, wr_done_ev;
  logic ready_q;

  sram_seq_fsm #(
    .T_READ (T_READ),
    .T_WP   (T_WP),
    .T_DW   (T_DW),
    .T_OHZ  (T_OHZ)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req           (req),
    .wr            (wr),
    .accept_ev     (accept_ev),
    .rd_capture_ev (rd_capture_ev),
    .wr_done_ev    (wr_done_ev),
    .ce1_n         (ce1_n),
    .ce2           (ce2),
    .oe_n          (oe_n),
    .we_n          (we_n),
    .drive         (dq_oe)
  );

  sram_bus_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept_ev),
    .host_addr  (addr),
    .host_wdata (wdata),
    .capture    (rd_capture_ev),
    .dq_in      (dq_in),
    .sram_addr  (sram_addr),
    .dq_out     (dq_out),
    .rdata      (rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= rd_capture_ev | wr_done_ev;
  end

  assign ready = ready_q;
endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk #(
  parameter int unsigned AW    = 13,
  parameter int unsigned T_WP  = 2,
  parameter int unsigned T_DW  = 2,
  parameter int unsigned T_OHZ = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce1_n,
  input logic          ce2,
  input logic          oe_n,
  input logic          we_n,
  input logic          dq_oe,
  input logic          ready,
  input logic          accept_ev,
  input logic [AW-1:0] sram_addr
);
  localparam int unsigned STB  = sram_ctrl_pkg::strobe_cycles(T_WP, T_DW);
  localparam int unsigned CMAX = T_OHZ + STB + T_DW + 2;
  localparam int unsigned CW   = sram_ctrl_pkg::cnt_bits(CMAX);
  localparam logic [CW-1:0] CSAT = CW'(CMAX);

  logic          sel;
  logic [CW-1:0] oe_hi_cnt, we_lo_cnt, drv_cnt;

  assign sel = !ce1_n && ce2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_hi_cnt <= CSAT;
      we_lo_cnt <= '0;
      drv_cnt   <= '0;
    end else begin
      oe_hi_cnt <= !oe_n ? '0 : ((oe_hi_cnt == CSAT) ? CSAT : oe_hi_cnt + CW'(1));
      we_lo_cnt <= we_n  ? '0 : ((we_lo_cnt == CSAT) ? CSAT : we_lo_cnt + CW'(1));
      drv_cnt   <= !dq_oe ? '0 : ((drv_cnt == CSAT) ? CSAT : drv_cnt + CW'(1));
    end
  end

  // R9
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  // R6
  drv_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);

  // R6
  drv_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && we_n) |=> !we_n);

  // R6
  we_needs_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> dq_oe);

  // R7
  ohz_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (32'(oe_hi_cnt) > T_OHZ));

  // R5
  strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> ((32'(we_lo_cnt) >= STB) && (32'(drv_cnt) >= T_DW)));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && $past(sel)) |-> $stable(sram_addr));

  // R8
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  // R2
  accept_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> sel);

  // R4
  read_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (sel && we_n));
endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(
  .AW    (AW),
  .T_WP  (T_WP),
  .T_DW  (T_DW),
  .T_OHZ (T_OHZ)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce1_n     (ce1_n),
  .ce2       (ce2),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .dq_oe     (dq_oe),
  .ready     (ready),
  .accept_ev (accept_ev),
  .sram_addr (sram_addr)
);

// File: tb/sim_sram_seq_ctrl.sv
`timescale 1ns/1ps
module sim_sram_seq_ctrl;
  localparam int AW    = 10;
  localparam int DW    = 8;
  localparam int TR    = 3;
  localparam int TWP   = 2;
  localparam int TDW   = 4;
  localparam int TOHZ  = 2;
  localparam int WORDS = 1 << AW;
  localparam int STRB  = ((TDW - 1) > TWP) ? (TDW - 1) : TWP;
  localparam int WR_LAT = STRB + 3;
  localparam int RD_LAT = TR + 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req, wr;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic          ready;
  logic [DW-1:0] rdata;
  logic [AW-1:0] sram_addr;
  logic          ce1_n, ce2, oe_n, we_n, dq_oe;
  logic [DW-1:0] dq_out, dq_in;

  always #2.5 clk = ~clk;

  sram_seq_ctrl #(
    .AW(AW), .DW(DW), .T_READ(TR), .T_WP(TWP), .T_DW(TDW), .T_OHZ(TOHZ)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .ready(ready), .rdata(rdata), .sram_addr(sram_addr), .ce1_n(ce1_n),
    .ce2(ce2), .oe_n(oe_n), .we_n(we_n), .dq_out(dq_out), .dq_oe(dq_oe),
    .dq_in(dq_in)
  );

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a, input int pass);
    return 8'(((a * 37) + (a >> 3) + (pass * 91)) ^ 8'h5A);
  endfunction

  // RAM model: slow access, late bus release, stores on write-strobe rise
  logic [7:0]    ram [WORDS];
  int            rd_cnt, tail, we_lo, drv_run;
  logic [AW-1:0] prev_addr, hold_addr;
  logic [7:0]    prev_dq, hold_dq, model_q;
  logic          model_drv, sel_now, rdc_now;

  assign dq_in = model_drv ? model_q : dq_out;

  always @(negedge clk) begin
    if (!rst_n) begin
      rd_cnt = 0; tail = 0; we_lo = 0; drv_run = 0;
      model_drv = 1'b0; model_q = '0; prev_addr = '0; prev_dq = '0;
      hold_addr = '0; hold_dq = '0;
    end else begin
      sel_now = !ce1_n && ce2;
      rdc_now = sel_now && !oe_n && we_n;
      if (rdc_now) begin
        rd_cnt = (rd_cnt > 0 && sram_addr == prev_addr) ? rd_cnt + 1 : 1;
        tail = TOHZ;
        model_drv = 1'b1;
      end else begin
        rd_cnt = 0;
        if (tail > 0) begin tail--; model_drv = 1'b1; end
        else model_drv = 1'b0;
      end
      model_q = (rdc_now && rd_cnt > TR) ? ram[sram_addr] : (ram[sram_addr] ^ 8'hA5);
      // R7: no overlap with the RAM's late release
      if (dq_oe) chk(!model_drv, "R7 data bus driven twice", int'(model_drv), 0);
      // R5: strobe width and data set-up at the rising write strobe
      if (we_n && we_lo > 0) begin
        chk(we_lo >= TWP && drv_run >= TDW, "R5 strobe/setup cycles",
            we_lo * 100 + drv_run, STRB * 100 + STRB + 1);
        ram[hold_addr] = hold_dq;
        we_lo = 0;
      end else if (!we_n && sel_now) begin
        we_lo++;
        hold_dq = dq_out;
        hold_addr = sram_addr;
      end
      drv_run = dq_oe ? ((drv_run > 0 && dq_out == prev_dq) ? drv_run + 1 : 1) : 0;
      prev_dq = dq_out;
      prev_addr = sram_addr;
    end
  end

  // Called at a negedge; returns at the negedge where ready is seen.
  task automatic access(input bit w, input int a, input logic [7:0] d,
                        input int exp_lat, input string tag);
    int  lat = 0;
    bit  done = 0;
    bit  lead = 0;
    req = 1'b1; wr = w; addr = AW'(a); wdata = d;
    while (!done && lat < 64) begin
      @(negedge clk);
      lat++;
      if (!ce1_n && ce2) chk(sram_addr == AW'(a), "R3 address while selected", int'(sram_addr), a);
      chk(!(!oe_n && !we_n), "R9 OE_n and WE_n both low", int'({oe_n, we_n}), 1);
      if (dq_oe) chk(oe_n == 1'b1, "R6 driver while OE_n low", int'(oe_n), 1);
      if (lead) chk(!we_n, "R6 lead cycle not followed by strobe", int'(we_n), 0);
      lead = dq_oe && we_n;
      if (ready) done = 1;
    end
    req = 1'b0;
    chk(lat == exp_lat, tag, lat, exp_lat);
    chk(ce1_n && !ce2 && oe_n && we_n && !dq_oe, "R2 idle pins at ready",
        int'({ce1_n, ce2, oe_n, we_n, dq_oe}), 5'b10110);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit prev_rd = 0;
    logic [7:0] last_rd = '0;
    rst_n = 1'b0; req = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ce1_n == 1'b1, "R1 ce1_n in reset", int'(ce1_n), 1);
    chk(ce2 == 1'b0,   "R1 ce2 in reset",   int'(ce2), 0);
    chk(oe_n == 1'b1,  "R1 oe_n in reset",  int'(oe_n), 1);
    chk(we_n == 1'b1,  "R1 we_n in reset",  int'(we_n), 1);
    chk(dq_oe == 1'b0, "R1 dq_oe in reset", int'(dq_oe), 0);
    chk(ready == 1'b0, "R1 ready in reset", int'(ready), 0);
    chk(rdata == '0,   "R1 rdata in reset", int'(rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ce1_n && !ce2 && oe_n && we_n && !dq_oe, "R1 pins after release",
        int'({ce1_n, ce2, oe_n, we_n, dq_oe}), 5'b10110);

    // Sweep 1: store every word
    for (int a = 0; a < WORDS; a++) begin
      access(1'b1, a, pat(a, 0), WR_LAT, "R5 write latency");
      prev_rd = 0;
    end
    // Sweep 2: load every word, back to back
    for (int a = 0; a < WORDS; a++) begin
      access(1'b0, a, 8'h00, RD_LAT + (prev_rd ? TOHZ : 0),
             prev_rd ? "R8 held-off read latency" : "R4 read latency");
      chk(rdata == pat(a, 0), "R4 read data sweep 1", int'(rdata), int'(pat(a, 0)));
      prev_rd = 1;
    end
    // Sweep 3: descending, store then load back each word
    for (int a = WORDS - 1; a >= 0; a--) begin
      access(1'b1, a, pat(a, 1), WR_LAT + (prev_rd ? TOHZ : 0),
             prev_rd ? "R8 held-off write latency" : "R5 write latency");
      access(1'b0, a, 8'h00, RD_LAT, "R4 read after write latency");
      chk(rdata == pat(a, 1), "R4 read data sweep 2", int'(rdata), int'(pat(a, 1)));
      last_rd = pat(a, 1);
      prev_rd = 1;
    end
    // R8 single pulse, R4 hold, R2 idle
    @(negedge clk);
    chk(ready == 1'b0, "R8 ready longer than one cycle", int'(ready), 0);
    chk(rdata == last_rd, "R4 rdata not held", int'(rdata), int'(last_rd));
    repeat (4) @(negedge clk);
    chk(ce1_n && !ce2 && oe_n && we_n && !dq_oe, "R2 idle pins without request",
        int'({ce1_n, ce2, oe_n, we_n, dq_oe}), 5'b10110);
    chk(ready == 1'b0, "R8 ready without request", int'(ready), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule